// File: doc/BRIEF.md
# Packed Lane Pack and Interleave Unit

This unit is a purely combinational rearrangement stage for packed integer operands. It takes two operands, A (destination side) and B (source side), and an opcode byte. It produces one result word. The result is one of two kinds. A pack narrows every lane of both operands to half its width and clamps out-of-range values to the nearest limit. An unpack interleaves equal-sized elements taken from either the upper or the lower half of both operands.

It sits in an execution cluster after operand selection. Its output is registered by the consumer. An opcode outside the supported set raises `illegal_o` and forces the result to zero, so the consumer can raise its own fault.

Top module: `ppu_pack_unpack`

## Requirements
- R1: Opcode 8'h63 turns each signed 16-bit lane into a signed 8-bit lane. Values above 127 become 8'h7F, values below -128 become 8'h80, and all other values keep their low byte.
- R2: Opcode 8'h67 reads each 16-bit lane as signed and produces an unsigned 8-bit lane. Negative values become 8'h00, values above 255 become 8'hFF, and all other values keep their low byte.
- R3: Opcode 8'h6B turns each signed 32-bit lane into a signed 16-bit lane. Values above 32767 become 16'h7FFF, values below -32768 become 16'h8000, and all other values keep their low half.
- R4: In every pack, the narrowed lanes of A fill the lower half of the result in lane order, and the narrowed lanes of B fill the upper half.
- R5: Opcodes 8'h68, 8'h69 and 8'h6A interleave the elements of the upper halves of A and B, with elements of 8, 16 and 32 bits respectively.
- R6: Opcodes 8'h60, 8'h61 and 8'h62 interleave the elements of the lower halves of A and B, with elements of 8, 16 and 32 bits respectively.
- R7: In every interleave, result pair k holds element k of the chosen half of A in its lower position and element k of the chosen half of B in its upper position.
- R8: Any other opcode sets `illegal_o` to 1 and drives the result to all zeros.
- R9: The nine supported opcodes drive `illegal_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode_i | input | OP_W (8) | Operation select byte |
| a_i | input | DATA_W (64) | Operand A (destination side) |
| b_i | input | DATA_W (64) | Operand B (source side) |
| result_o | output | DATA_W (64) | Packed or interleaved result |
| illegal_o | output | 1 | High for an unsupported opcode |

## Verification
The bench builds the unit with its default values, DATA_W of 64 and OP_W of 8. Every lane count is therefore small: four word lanes per operand, two doubleword lanes, and pairs of 4, 2 and 1 in the interleaves. Lane placement can then be checked in full. With those lane counts, the directed operand words can place every clamp edge (127/128, -128/-129, 255/256, 0/-1, 32767/32768, -32768/-32769) in every lane position. With the 8-bit opcode, the bench also reaches unsupported codes lying right beside the supported ones.

// File: rtl/ppu_pkg.sv
package ppu_pkg;

   // Opcode byte values decoded by the unit
   localparam logic [7:0] OPC_ILV_LO_8  = 8'h60;
   localparam logic [7:0] OPC_ILV_LO_16 = 8'h61;
   localparam logic [7:0] OPC_ILV_LO_32 = 8'h62;
   localparam logic [7:0] OPC_NAR_S16   = 8'h63;
   localparam logic [7:0] OPC_NAR_U16   = 8'h67;
   localparam logic [7:0] OPC_ILV_HI_8  = 8'h68;
   localparam logic [7:0] OPC_ILV_HI_16 = 8'h69;
   localparam logic [7:0] OPC_ILV_HI_32 = 8'h6A;
   localparam logic [7:0] OPC_NAR_S32   = 8'h6B;

   // Number of interleave element sizes (8, 16, 32)
   localparam int ILV_SIZES = 3;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_NAR_S16,
      SEL_NAR_U16,
      SEL_NAR_S32,
      SEL_ILV_LO,
      SEL_ILV_HI
   } sel_e;

endpackage

// File: rtl/ppu_sat_narrow.sv
module ppu_sat_narrow #(
   parameter int IN_W         = 16,
   parameter int OUT_W        = 8,
   parameter bit UNSIGNED_OUT = 1'b0
) (
   input  logic [IN_W-1:0]  lane_i,
   output logic [OUT_W-1:0] lane_o
);

   generate
      if (IN_W < OUT_W + 2) begin : g_bad_width
         $error("ppu_sat_narrow: IN_W must exceed OUT_W by at least two");
      end

      if (UNSIGNED_OUT) begin : g_uns
         logic above;
         assign above = |lane_i[IN_W-2:OUT_W];
         always_comb begin
            if (lane_i[IN_W-1])
               lane_o = '0;
            else if (above)
               lane_o = '1;
            else
               lane_o = lane_i[OUT_W-1:0];
         end
      end else begin : g_sgn
         localparam int TOP_W = IN_W - OUT_W + 1;
         logic [TOP_W-1:0] top_bits;
         logic             fits;
         assign top_bits = lane_i[IN_W-1:OUT_W-1];
         assign fits     = (top_bits == '0) || (top_bits == '1);
         always_comb begin
            if (fits)
               lane_o = lane_i[OUT_W-1:0];
            else
               lane_o = {lane_i[IN_W-1], {(OUT_W-1){~lane_i[IN_W-1]}}};
         end
      end
   endgenerate

endmodule

// File: rtl/ppu_pack.sv
module ppu_pack #(
   parameter int DATA_W       = 64,
   parameter int IN_W         = 16,
   parameter bit UNSIGNED_OUT = 1'b0
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   output logic [DATA_W-1:0] res_o
);

   localparam int OUT_W = IN_W / 2;
   localparam int LANES = DATA_W / IN_W;

   generate
      if (DATA_W % IN_W != 0) begin : g_bad_lanes
         $error("ppu_pack: DATA_W must be a multiple of IN_W");
      end

      for (genvar i = 0; i < LANES; i++) begin : g_lane
         ppu_sat_narrow #(
            .IN_W(IN_W), .OUT_W(OUT_W), .UNSIGNED_OUT(UNSIGNED_OUT)
         ) u_nar_a (
            .lane_i(a_i[i*IN_W +: IN_W]),
            .lane_o(res_o[i*OUT_W +: OUT_W])
         );
         ppu_sat_narrow #(
            .IN_W(IN_W), .OUT_W(OUT_W), .UNSIGNED_OUT(UNSIGNED_OUT)
         ) u_nar_b (
            .lane_i(b_i[i*IN_W +: IN_W]),
            .lane_o(res_o[(LANES+i)*OUT_W +: OUT_W])
         );
      end
   endgenerate

endmodule

// File: rtl/ppu_interleave.sv
module ppu_interleave #(
   parameter int DATA_W = 64,
   parameter int ELEM_W = 8,
   parameter bit HIGH   = 1'b0
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   output logic [DATA_W-1:0] res_o
);

   localparam int ELEMS = DATA_W / ELEM_W;
   localparam int PAIRS = ELEMS / 2;
   localparam int BASE  = HIGH ? PAIRS : 0;

   generate
      if (ELEMS < 2 || DATA_W % ELEM_W != 0) begin : g_bad_elem
         $error("ppu_interleave: DATA_W must hold an even number of elements");
      end

      for (genvar i = 0; i < PAIRS; i++) begin : g_pair
         assign res_o[(2*i)*ELEM_W   +: ELEM_W] = a_i[(BASE+i)*ELEM_W +: ELEM_W];
         assign res_o[(2*i+1)*ELEM_W +: ELEM_W] = b_i[(BASE+i)*ELEM_W +: ELEM_W];
      end
   endgenerate

endmodule

// File: rtl/ppu_pack_unpack.sv
module ppu_pack_unpack #(
   parameter int DATA_W = 64,
   parameter int OP_W   = 8
) (
   input  logic [OP_W-1:0]   opcode_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   output logic [DATA_W-1:0] result_o,
   output logic              illegal_o
);
   import ppu_pkg::*;

   localparam logic [OP_W-1:0] K_LO8  = OP_W'(OPC_ILV_LO_8);
   localparam logic [OP_W-1:0] K_LO16 = OP_W'(OPC_ILV_LO_16);
   localparam logic [OP_W-1:0] K_LO32 = OP_W'(OPC_ILV_LO_32);
   localparam logic [OP_W-1:0] K_S16  = OP_W'(OPC_NAR_S16);
   localparam logic [OP_W-1:0] K_U16  = OP_W'(OPC_NAR_U16);
   localparam logic [OP_W-1:0] K_HI8  = OP_W'(OPC_ILV_HI_8);
   localparam logic [OP_W-1:0] K_HI16 = OP_W'(OPC_ILV_HI_16);
   localparam logic [OP_W-1:0] K_HI32 = OP_W'(OPC_ILV_HI_32);
   localparam logic [OP_W-1:0] K_S32  = OP_W'(OPC_NAR_S32);

   generate
      if (DATA_W < 64 || DATA_W % 64 != 0) begin : g_bad_data
         $error("ppu_pack_unpack: DATA_W must be a positive multiple of 64");
      end
      if (OP_W < 8) begin : g_bad_op
         $error("ppu_pack_unpack: OP_W must be at least 8");
      end
   endgenerate

   logic [DATA_W-1:0] nar_s16, nar_u16, nar_s32;
   logic [DATA_W-1:0] ilv_lo [ILV_SIZES];
   logic [DATA_W-1:0] ilv_hi [ILV_SIZES];
   sel_e              sel;
   logic [1:0]        size_idx;

   ppu_pack #(.DATA_W(DATA_W), .IN_W(16), .UNSIGNED_OUT(1'b0)) u_pack_s16 (
      .a_i(a_i), .b_i(b_i), .res_o(nar_s16));
   ppu_pack #(.DATA_W(DATA_W), .IN_W(16), .UNSIGNED_OUT(1'b1)) u_pack_u16 (
      .a_i(a_i), .b_i(b_i), .res_o(nar_u16));
   ppu_pack #(.DATA_W(DATA_W), .IN_W(32), .UNSIGNED_OUT(1'b0)) u_pack_s32 (
      .a_i(a_i), .b_i(b_i), .res_o(nar_s32));

   generate
      for (genvar s = 0; s < ILV_SIZES; s++) begin : g_ilv
         ppu_interleave #(.DATA_W(DATA_W), .ELEM_W(8 << s), .HIGH(1'b0)) u_lo (
            .a_i(a_i), .b_i(b_i), .res_o(ilv_lo[s]));
         ppu_interleave #(.DATA_W(DATA_W), .ELEM_W(8 << s), .HIGH(1'b1)) u_hi (
            .a_i(a_i), .b_i(b_i), .res_o(ilv_hi[s]));
      end
   endgenerate

   // Opcode decode
   always_comb begin
      sel      = SEL_NONE;
      size_idx = 2'd0;
      case (opcode_i)
         K_LO8:   begin sel = SEL_ILV_LO; size_idx = 2'd0; end
         K_LO16:  begin sel = SEL_ILV_LO; size_idx = 2'd1; end
         K_LO32:  begin sel = SEL_ILV_LO; size_idx = 2'd2; end
         K_HI8:   begin sel = SEL_ILV_HI; size_idx = 2'd0; end
         K_HI16:  begin sel = SEL_ILV_HI; size_idx = 2'd1; end
         K_HI32:  begin sel = SEL_ILV_HI; size_idx = 2'd2; end
         K_S16:   sel = SEL_NAR_S16;
         K_U16:   sel = SEL_NAR_U16;
         K_S32:   sel = SEL_NAR_S32;
         default: sel = SEL_NONE;
      endcase
   end

   // Result selection
   always_comb begin
      illegal_o = 1'b0;
      result_o  = '0;
      case (sel)
         SEL_NAR_S16: result_o = nar_s16;
         SEL_NAR_U16: result_o = nar_u16;
         SEL_NAR_S32: result_o = nar_s32;
         SEL_ILV_LO:  result_o = (size_idx == 2'd0) ? ilv_lo[0] :
                                 (size_idx == 2'd1) ? ilv_lo[1] : ilv_lo[2];
         SEL_ILV_HI:  result_o = (size_idx == 2'd0) ? ilv_hi[0] :
                                 (size_idx == 2'd1) ? ilv_hi[1] : ilv_hi[2];
         default:     illegal_o = 1'b1;
      endcase
   end

endmodule

// File: rtl/ppu_pack_unpack_chk.sv
module ppu_pack_unpack_chk #(
   parameter int DATA_W = 64,
   parameter int OP_W   = 8
) (
   input logic [OP_W-1:0]   opcode_i,
   input logic [DATA_W-1:0] a_i,
   input logic [DATA_W-1:0] b_i,
   input logic [DATA_W-1:0] result_o,
   input logic              illegal_o
);
   localparam int H = DATA_W / 2;

   logic [7:0] op8;
   logic       hi_bits_zero;
   assign op8          = opcode_i[7:0];
   assign hi_bits_zero = (opcode_i >> 8) == '0;

   always_comb begin
      // R8: an unsupported opcode yields a zero result
      p_illegal_zero_r8: assert (!illegal_o || result_o == '0);

      // R9: supported opcodes are never flagged
      if (hi_bits_zero && (op8 inside {8'h60, 8'h61, 8'h62, 8'h63, 8'h67,
                                       8'h68, 8'h69, 8'h6A, 8'h6B}))
         p_legal_flag_r9: assert (!illegal_o);

      // R1: a signed word above 127 clamps to 8'h7F
      if (!illegal_o && opcode_i == OP_W'(8'h63) && !a_i[15] && a_i[14:7] != 8'h00)
         p_ssat_high_r1: assert (result_o[7:0] == 8'h7F);

      // R2: a negative word clamps to zero
      if (!illegal_o && opcode_i == OP_W'(8'h67) && a_i[15])
         p_usat_neg_r2: assert (result_o[7:0] == 8'h00);

      // R3: a doubleword below -32768 clamps to 16'h8000
      if (!illegal_o && opcode_i == OP_W'(8'h6B) && ($signed(a_i[31:0]) < -32768))
         p_dsat_low_r3: assert (result_o[15:0] == 16'h8000);

      // R6 R7: low byte interleave puts A first, B second
      if (opcode_i == OP_W'(8'h60))
         p_ilv_lo_order_r6: assert (result_o[7:0] == a_i[7:0] && result_o[15:8] == b_i[7:0]);

      // R5: widest high interleave is the two upper halves side by side
      if (opcode_i == OP_W'(8'h6A) && DATA_W == 64)
         p_ilv_hi_dw_r5: assert (result_o[H-1:0] == a_i[DATA_W-1:H] &&
                                 result_o[DATA_W-1:H] == b_i[DATA_W-1:H]);
   end

endmodule

bind ppu_pack_unpack ppu_pack_unpack_chk #(.DATA_W(DATA_W), .OP_W(OP_W)) u_chk (
   .opcode_i(opcode_i),
   .a_i(a_i),
   .b_i(b_i),
   .result_o(result_o),
   .illegal_o(illegal_o)
);

// File: tb/ppu_pack_unpack_tb.sv
module ppu_pack_unpack_tb;

   logic        clk = 1'b0;
   logic [7:0]  opcode;
   logic [63:0] a, b;
   logic [63:0] result;
   logic        illegal;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   ppu_pack_unpack #(.DATA_W(64), .OP_W(8)) u_dut (
      .opcode_i(opcode), .a_i(a), .b_i(b), .result_o(result), .illegal_o(illegal));

   function automatic longint clamp(longint v, longint lo, longint hi);
      if (v < lo) return lo;
      if (v > hi) return hi;
      return v;
   endfunction

   // Behavioural reference model
   function automatic logic [63:0] model(input logic [7:0] op, input logic [63:0] x,
                                         input logic [63:0] y, output bit ill);
      logic [63:0] r = '0;
      ill = 1'b0;
      case (op)
         8'h63, 8'h67: begin
            for (int i = 0; i < 4; i++) begin
               longint va = longint'($signed(x[16*i +: 16]));
               longint vb = longint'($signed(y[16*i +: 16]));
               longint lo = (op == 8'h63) ? -128 : 0;
               longint hi = (op == 8'h63) ? 127 : 255;
               r[8*i +: 8]     = 8'(clamp(va, lo, hi));
               r[8*(4+i) +: 8] = 8'(clamp(vb, lo, hi));
            end
         end
         8'h6B: begin
            for (int i = 0; i < 2; i++) begin
               longint va = longint'($signed(x[32*i +: 32]));
               longint vb = longint'($signed(y[32*i +: 32]));
               r[16*i +: 16]     = 16'(clamp(va, -32768, 32767));
               r[16*(2+i) +: 16] = 16'(clamp(vb, -32768, 32767));
            end
         end
         8'h60, 8'h61, 8'h62, 8'h68, 8'h69, 8'h6A: begin
            int es   = 8 << op[1:0];
            int n    = 32 / es;
            int base = op[3] ? n : 0;
            for (int i = 0; i < n; i++)
               for (int j = 0; j < es; j++) begin
                  r[2*i*es + j]      = x[(base+i)*es + j];
                  r[(2*i+1)*es + j]  = y[(base+i)*es + j];
               end
         end
         default: ill = 1'b1;
      endcase
      return r;
   endfunction

   function automatic string tag_of(input logic [7:0] op);
      case (op)
         8'h63: return "R1 R4";
         8'h67: return "R2 R4";
         8'h6B: return "R3 R4";
         8'h68, 8'h69, 8'h6A: return "R5 R7";
         8'h60, 8'h61, 8'h62: return "R6 R7";
         default: return "R8";
      endcase
   endfunction

   task automatic apply(input logic [7:0] op, input logic [63:0] x, input logic [63:0] y);
      logic [63:0] exp_r;
      bit          exp_ill;
      @(negedge clk);
      opcode = op; a = x; b = y;
      @(posedge clk);
      #1;
      exp_r = model(op, x, y, exp_ill);
      checks++;
      if (result !== exp_r) begin
         fails++;
         $display("FAIL %s op=%h a=%h b=%h result actual=%h expected=%h",
                  tag_of(op), op, x, y, result, exp_r);
      end
      checks++;
      if (illegal !== exp_ill) begin
         fails++;
         $display("FAIL %s op=%h illegal actual=%b expected=%b",
                  exp_ill ? "R8" : "R9", op, illegal, exp_ill);
      end
   endtask

   localparam int NW = 12;
   localparam int ND = 10;
   logic [15:0] wv [NW] = '{16'h007F, 16'h0080, 16'h00FF, 16'h0100, 16'hFFFF, 16'hFF80,
                            16'hFF7F, 16'h7FFF, 16'h8000, 16'h0000, 16'h0001, 16'h0055};
   logic [31:0] dv [ND] = '{32'h00007FFF, 32'h00008000, 32'hFFFF8000, 32'hFFFF7FFF,
                            32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF, 32'h00000000,
                            32'h00012345, 32'hFFFF8001};
   logic [7:0]  ops [14] = '{8'h60, 8'h61, 8'h62, 8'h63, 8'h67, 8'h68, 8'h69,
                             8'h6A, 8'h6B, 8'h00, 8'h64, 8'h5F, 8'h6C, 8'hFF};

   task automatic all_ops(input logic [63:0] x, input logic [63:0] y);
      for (int k = 0; k < 14; k++) apply(ops[k], x, y);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : stim
      logic [63:0] lfsr = 64'hACE1_2468_1357_BDF9;
      opcode = 8'h00; a = '0; b = '0;
      // Idle state: zero inputs, unsupported opcode (R8)
      apply(8'h00, 64'h0, 64'h0);
      // Word clamp edges in every lane position (R1 R2 R4)
      for (int k = 0; k < NW; k++)
         all_ops({wv[(k+3)%NW], wv[(k+2)%NW], wv[(k+1)%NW], wv[k]},
                 {wv[(k+9)%NW], wv[(k+8)%NW], wv[(k+7)%NW], wv[(k+6)%NW]});
      // Doubleword clamp edges (R3 R4)
      for (int k = 0; k < ND; k++)
         all_ops({dv[(k+1)%ND], dv[k]}, {dv[(k+4)%ND], dv[(k+7)%ND]});
      // Distinct byte patterns for interleave order (R5 R6 R7)
      all_ops(64'h0706050403020100, 64'h8F8E8D8C8B8A8988);
      // Pseudo-random operands
      for (int k = 0; k < 20; k++) begin
         logic [63:0] x, y;
         lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
         x = lfsr ^ (lfsr << 17);
         lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
         y = lfsr ^ (lfsr >> 11);
         all_ops(x, y);
      end
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule